// File: doc/BRIEF.md
# Local Interrupt Priority Acceptance Unit

This unit sits next to one processor core and decides, every cycle, whether some pending interrupt vector may be handed to that core. Requests arrive from two places: an external interrupt bus, which presents one vector at a time with a valid strobe, and a local register write that lets software post an interrupt to its own core. Every accepted request sets one bit in a 256-entry pending bitmap. A second 256-entry bitmap records the vectors whose handlers are running.

Priority depends only on a vector's class, which is its upper four bits. A pending vector is offered to the core only when its class is strictly above two thresholds: the class held in a writable task priority register, and the class of the highest vector in service. The core's interrupt-enable input must also be high. Software can therefore raise the task priority to hold back a group of low classes, and a vector it posts to itself waits until every higher-class handler has signalled end of interrupt.

The core accepts an offered vector with a one-cycle acknowledge pulse. That pulse moves the vector from pending to in service. An end-of-interrupt write retires the highest vector in service. The offer (`irqReq`, `irqVector`) is computed from registered state and the enable input with no register in between. A write or request that is sampled at one clock edge is therefore visible on the offer outputs straight after that edge.

Top module: `local_irq_gate`

## Requirements
- R1: A vector's class is bits [7:4]. A pending vector is not offered while a vector of the same or a higher class is in service.
- R2: A write to register address 0 sets the task priority. Every pending vector whose class is less than or equal to the written value's bits [7:4] is then held back. After writing 0x4B, vector 0x45 is held back and vector 0x50 is offered.
- R3: `irqReq` stays low while `coreIntEnable` is low. Pending vectors are kept, and they are offered once the enable goes high.
- R4: When several vectors may be offered, `irqVector` is the highest-numbered pending vector.
- R5: A `coreAck` pulse while `irqReq` is high moves the offered vector from pending to in service. A `coreAck` pulse while `irqReq` is low has no effect.
- R6: A write to register address 2 (end of interrupt; the data is ignored) clears only the highest in-service vector. Lower in-service vectors stay in place and keep blocking.
- R7: An end-of-interrupt write while nothing is in service has no effect.
- R8: Vectors 0x00 to 0x1F are discarded. This applies to bus requests and to self-interrupt writes.
- R9: A write to register address 1 posts the written value as a pending vector. It stays pending until the class rules allow delivery.
- R10: A request for a vector that is already pending is merged with it. One acknowledge and one end of interrupt leave nothing pending.
- R11: Reset clears both bitmaps and sets the task priority to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReqValid | input | 1 | External bus presents a vector this cycle |
| busReqVector | input | 8 | Vector from the external bus |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Register select: 0 task priority, 1 self interrupt, 2 end of interrupt |
| regWrData | input | 8 | Register write data |
| coreIntEnable | input | 1 | Core accepts interrupts |
| coreAck | input | 1 | Core takes the offered vector |
| irqReq | output | 1 | A vector is offered to the core |
| irqVector | output | 8 | The offered vector |

## Verification
The hardest situation to reach from the ports is a nested stack of in-service vectors: two or more vectors are in service at once, and a lower-class vector is pending beneath them. Only that state shows whether an end-of-interrupt write retires just the top entry and leaves the lower one blocking. The stimulus builds this state by acknowledging a vector, posting a vector of a higher class, acknowledging that one too, and then issuing end-of-interrupt writes one at a time. After each step it checks that the pending vector stays hidden until the last blocking entry has gone. The same sequence changes the task priority between these steps so that both thresholds are tested against each other.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;
  localparam int ADDR_W  = 2;

  // Strobes sent from the control module to the datapath for one cycle
  typedef struct packed {
    logic             busSet;
    logic [VEC_W-1:0] busVec;
    logic             selfSet;
    logic [VEC_W-1:0] selfVec;
    logic             ackDo;
    logic             eoiDo;
    logic             tprWr;
    logic [VEC_W-1:0] tprData;
  } gate_strobe_t;
endpackage

// File: rtl/hi_bit_find.sv
module hi_bit_find #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vecIn,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vecIn[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_gate_datapath.sv
module irq_gate_datapath
  import irq_gate_pkg::*;
#(
  parameter int VW = VEC_W,
  localparam int NV = 1 << VW
) (
  input  logic          clk,
  input  logic          rstN,
  input  gate_strobe_t  st,
  output logic          hpValid,
  output logic [VW-1:0] hpVec,
  output logic          isValid,
  output logic [VW-1:0] isVec,
  output logic [VW-1:0] tprVal
);
  logic [NV-1:0] pendReg, pendNext;
  logic [NV-1:0] servReg, servNext;
  logic [VW-1:0] tprReg;

  hi_bit_find #(.W(NV), .IW(VW)) uPendFind (
    .vecIn(pendReg), .found(hpValid), .idx(hpVec)
  );
  hi_bit_find #(.W(NV), .IW(VW)) uServFind (
    .vecIn(servReg), .found(isValid), .idx(isVec)
  );

  always_comb begin
    pendNext = pendReg;
    servNext = servReg;
    if (st.eoiDo && isValid) servNext[isVec] = 1'b0;
    if (st.ackDo && hpValid) begin
      pendNext[hpVec] = 1'b0;
      servNext[hpVec] = 1'b1;
    end
    if (st.busSet)  pendNext[st.busVec]  = 1'b1;
    if (st.selfSet) pendNext[st.selfVec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      servReg <= '0;
      tprReg  <= '0;
    end else begin
      pendReg <= pendNext;
      servReg <= servNext;
      if (st.tprWr) tprReg <= st.tprData;
    end
  end

  assign tprVal = tprReg;
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int VW  = VEC_W,
  parameter int CW  = CLASS_W,
  parameter int AW  = ADDR_W,
  parameter int RSV = 32
) (
  input  logic          busReqValid,
  input  logic [VW-1:0] busReqVector,
  input  logic          regWrEn,
  input  logic [AW-1:0] regWrAddr,
  input  logic [VW-1:0] regWrData,
  input  logic          coreIntEnable,
  input  logic          coreAck,
  input  logic          hpValid,
  input  logic [VW-1:0] hpVec,
  input  logic          isValid,
  input  logic [VW-1:0] isVec,
  input  logic [VW-1:0] tprVal,
  output gate_strobe_t  st,
  output logic          irqReq,
  output logic [VW-1:0] irqVector
);
  localparam logic [AW-1:0] ADDR_TPR  = AW'(0);
  localparam logic [AW-1:0] ADDR_SELF = AW'(1);
  localparam logic [AW-1:0] ADDR_EOI  = AW'(2);
  localparam logic [VW-1:0] RSV_LIM   = VW'(RSV);

  logic [CW-1:0] hpClass, isClass, tprClass;
  logic          aboveTpr, aboveServ, offer;

  assign hpClass  = hpVec[VW-1 -: CW];
  assign isClass  = isVec[VW-1 -: CW];
  assign tprClass = tprVal[VW-1 -: CW];

  assign aboveTpr  = hpClass > tprClass;
  assign aboveServ = !isValid || (hpClass > isClass);
  assign offer     = hpValid && aboveTpr && aboveServ && coreIntEnable;

  assign irqReq    = offer;
  assign irqVector = hpVec;

  always_comb begin
    st         = '0;
    st.busSet  = busReqValid && (busReqVector >= RSV_LIM);
    st.busVec  = busReqVector;
    st.selfSet = regWrEn && (regWrAddr == ADDR_SELF) && (regWrData >= RSV_LIM);
    st.selfVec = regWrData;
    st.tprWr   = regWrEn && (regWrAddr == ADDR_TPR);
    st.tprData = regWrData;
    st.eoiDo   = regWrEn && (regWrAddr == ADDR_EOI);
    st.ackDo   = coreAck && offer;
  end
endmodule

// File: rtl/local_irq_gate.sv
module local_irq_gate
  import irq_gate_pkg::*;
#(
  parameter int VW  = VEC_W,
  parameter int CW  = CLASS_W,
  parameter int AW  = ADDR_W,
  parameter int RSV = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReqValid,
  input  logic [VW-1:0] busReqVector,
  input  logic          regWrEn,
  input  logic [AW-1:0] regWrAddr,
  input  logic [VW-1:0] regWrData,
  input  logic          coreIntEnable,
  input  logic          coreAck,
  output logic          irqReq,
  output logic [VW-1:0] irqVector
);
  gate_strobe_t  st;
  logic          hpValid, isValid;
  logic [VW-1:0] hpVec, isVec, tprVal;

  irq_gate_ctrl #(.VW(VW), .CW(CW), .AW(AW), .RSV(RSV)) uCtrl (
    .busReqValid(busReqValid), .busReqVector(busReqVector),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .coreIntEnable(coreIntEnable), .coreAck(coreAck),
    .hpValid(hpValid), .hpVec(hpVec), .isValid(isValid), .isVec(isVec),
    .tprVal(tprVal), .st(st), .irqReq(irqReq), .irqVector(irqVector)
  );

  irq_gate_datapath #(.VW(VW)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .hpValid(hpValid), .hpVec(hpVec), .isValid(isValid), .isVec(isVec),
    .tprVal(tprVal)
  );
endmodule

// File: rtl/local_irq_gate_chk.sv
module local_irq_gate_chk #(
  parameter int VW  = 8,
  parameter int CW  = 4,
  parameter int RSV = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          coreIntEnable,
  input logic          coreAck,
  input logic          irqReq,
  input logic [VW-1:0] irqVector,
  input logic [VW-1:0] tprVal,
  input logic          isValid,
  input logic [VW-1:0] isVec
);
  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
    !coreIntEnable |-> !irqReq);

  a_r2_above_task_prio: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector[VW-1 -: CW] > tprVal[VW-1 -: CW]));

  a_r1_above_in_service: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && isValid) |-> (irqVector[VW-1 -: CW] > isVec[VW-1 -: CW]));

  a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector >= VW'(RSV)));

  a_r5_ack_retires_offer: assert property (@(posedge clk) disable iff (!rstN)
    (coreAck && irqReq) |=> !(irqReq && irqVector == $past(irqVector)));

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !irqReq);
endmodule

bind local_irq_gate local_irq_gate_chk #(.VW(VW), .CW(CW), .RSV(RSV)) uChk (
  .clk(clk), .rstN(rstN), .coreIntEnable(coreIntEnable), .coreAck(coreAck),
  .irqReq(irqReq), .irqVector(irqVector), .tprVal(tprVal),
  .isValid(isValid), .isVec(isVec)
);

// File: tb/local_irq_gate_test.sv
module local_irq_gate_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReqValid = 1'b0;
  logic [7:0] busReqVector = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic       coreIntEnable = 1'b1;
  logic       coreAck = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  local_irq_gate uut (
    .clk(clk), .rstN(rstN), .busReqValid(busReqValid), .busReqVector(busReqVector),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .coreIntEnable(coreIntEnable), .coreAck(coreAck),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  // op codes
  localparam logic [2:0] OP_IDLE = 3'd0, OP_BUS = 3'd1, OP_SELF = 3'd2,
                         OP_TPR = 3'd3, OP_EOI = 3'd4, OP_ACK = 3'd5;

  // {op, arg, expected irqReq, expected vector}
  localparam logic [19:0] TBL [0:20] = '{
    {OP_BUS,  8'h45, 1'b1, 8'h45},  // R4
    {OP_BUS,  8'h10, 1'b1, 8'h45},  // R8
    {OP_BUS,  8'h47, 1'b1, 8'h47},  // R4
    {OP_ACK,  8'h00, 1'b0, 8'h00},  // R1
    {OP_BUS,  8'h52, 1'b1, 8'h52},  // R1
    {OP_ACK,  8'h00, 1'b0, 8'h00},  // R5
    {OP_EOI,  8'h00, 1'b0, 8'h00},  // R6
    {OP_EOI,  8'h00, 1'b1, 8'h45},  // R6
    {OP_TPR,  8'h4B, 1'b0, 8'h00},  // R2
    {OP_BUS,  8'h50, 1'b1, 8'h50},  // R2
    {OP_ACK,  8'h00, 1'b0, 8'h00},  // R5
    {OP_EOI,  8'h00, 1'b0, 8'h00},  // R2
    {OP_EOI,  8'h00, 1'b0, 8'h00},  // R7
    {OP_TPR,  8'h30, 1'b1, 8'h45},  // R2
    {OP_ACK,  8'h00, 1'b0, 8'h00},  // R5
    {OP_SELF, 8'h2A, 1'b0, 8'h00},  // R9
    {OP_EOI,  8'h00, 1'b0, 8'h00},  // R9
    {OP_TPR,  8'h00, 1'b1, 8'h2A},  // R9
    {OP_SELF, 8'h05, 1'b1, 8'h2A},  // R8
    {OP_ACK,  8'h00, 1'b0, 8'h00},  // R5
    {OP_EOI,  8'h00, 1'b0, 8'h00}   // R8
  };

  task automatic doOp(input logic [2:0] kind, input logic [7:0] arg);
    case (kind)
      OP_BUS:  begin busReqValid = 1'b1; busReqVector = arg; end
      OP_SELF: begin regWrEn = 1'b1; regWrAddr = 2'd1; regWrData = arg; end
      OP_TPR:  begin regWrEn = 1'b1; regWrAddr = 2'd0; regWrData = arg; end
      OP_EOI:  begin regWrEn = 1'b1; regWrAddr = 2'd2; regWrData = arg; end
      OP_ACK:  coreAck = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    busReqValid = 1'b0;
    regWrEn = 1'b0;
    coreAck = 1'b0;
  endtask

  task automatic check(input string req, input logic expReq, input logic [7:0] expVec);
    checks++;
    if (irqReq !== expReq || (expReq && irqVector !== expVec)) begin
      errors++;
      $display("FAIL %s: irqReq=%0b irqVector=%02h expected irqReq=%0b irqVector=%02h",
               req, irqReq, irqVector, expReq, expVec);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset state", 1'b0, 8'h00);

    for (int i = 0; i < 21; i++) begin
      doOp(TBL[i][19:17], TBL[i][16:9]);
      check($sformatf("table step %0d (R1..R10 sequence)", i), TBL[i][8], TBL[i][7:0]);
    end

    // R3: enable low hides a pending vector
    coreIntEnable = 1'b0;
    doOp(OP_BUS, 8'h80);
    check("R3 enable low", 1'b0, 8'h00);
    // R5: acknowledge while nothing offered is ignored
    doOp(OP_ACK, 8'h00);
    check("R5 stray ack", 1'b0, 8'h00);
    coreIntEnable = 1'b1;
    #1;
    check("R3 enable high offers kept vector", 1'b1, 8'h80);
    doOp(OP_ACK, 8'h00);
    check("R5 ack retires offer", 1'b0, 8'h00);
    doOp(OP_EOI, 8'h00);
    check("R6 eoi empties service", 1'b0, 8'h00);

    // R10: duplicate requests merge
    doOp(OP_BUS, 8'h90);
    doOp(OP_BUS, 8'h90);
    check("R10 duplicate offered", 1'b1, 8'h90);
    doOp(OP_ACK, 8'h00);
    doOp(OP_EOI, 8'h00);
    check("R10 merged, nothing left", 1'b0, 8'h00);

    // R11: reset mid-run clears pending and task priority
    doOp(OP_BUS, 8'h60);
    doOp(OP_TPR, 8'h70);
    check("R2 tpr 0x70 blocks 0x60", 1'b0, 8'h00);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R11 reset clears pending", 1'b0, 8'h00);
    doOp(OP_BUS, 8'h25);
    check("R11 tpr back to 0", 1'b1, 8'h25);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule